// File: doc/BRIEF.md
# Structured Extended-IRA LDPC Systematic Encoder

This block encodes frames for a rate-1/2 extended irregular-repeat-accumulate LDPC code. The information part of the parity-check matrix is a 7 x 7 grid of N x N blocks. Each block is either zero or a permuted identity. Which blocks are nonzero is fixed by a (7,3,1) projective-plane arrangement, so any two block columns share at most one block row. That arrangement rules out length-4 cycles. The positions of the ones inside each permuted block are not stored anywhere. A small modular-stepping pointer generator produces them on the fly, with a step size (its root) chosen per block.

A frame of 7N information bits is first written serially into seven N-bit column memories. The encoder then sends the same 7N bits back unchanged. After them come 7N parity bits, one per check row. Because the parity part of the matrix is dual-diagonal, each parity bit is the XOR of the previous parity bit and the information bits that the active blocks select for that row. Both streams use valid/ready flow control, and the last parity bit of a frame is flagged.

Top module: `eira_ldpc_enc`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and any partially loaded frame is abandoned.
- R2: in_ready stays 1 until 7N bits have been accepted, then stays 0 until the frame's last parity bit has been registered.
- R3: The first 7N output bits equal the accepted input bits in arrival order. Input bit j belongs to block column j / N at local index j mod N.
- R4: Check row t = r*N + l (block row r, local row l) selects, in each active block column c, the local bit (g*(l+1)) mod N, where g = ((3r + 5c) mod (N-1)) + 1. Parity p(t) equals p(t-1) XOR the selected bits, with p(-1) = 0.
- R5: Block (r, c) is nonzero exactly when (r - c) mod 7 is 0, 1 or 3. Each block row therefore has three active columns, and a lone set information bit touches exactly three check rows.
- R6: Every check row of H is satisfied by the emitted codeword: its two parity bits XOR its selected information bits give 0.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_bit and out_last keep their values.
- R8: out_last is 1 on the last parity bit of a frame and 0 on every other output bit, and in_ready is 1 once that bit is in the output register.
- R9: A frame loaded after a reset that cut a previous load short is encoded from its own bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Information bit present |
| in_ready | output | 1 | Encoder accepts an information bit |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Codeword bit, systematic part first, then parity |
| out_last | output | 1 | Marks the final parity bit of the frame |

## Verification
The hardest case to reach is a backpressure stall that falls on the last local row of a block row. At that point the pointer generators must reload a new root while the output register is frozen. The stall pattern drops out_ready one cycle in three. Because 3 is coprime to N, stalls land on every local position, including each row end. A second hard case is a reset partway through loading. A directed test cuts a load short, resets, and then encodes a full fresh frame.

// File: rtl/eira_pkg.sv
package eira_pkg;
  localparam int BLK = 7;

  // Nonzero block placement: cyclic difference set {0,1,3} modulo BLK
  function automatic logic blk_active(input int r, input int c);
    int d;
    d = ((r - c) % BLK + BLK) % BLK;
    return (d == 0) || (d == 1) || (d == 3);
  endfunction

  // Generator step for block (r,c); nonzero modulo the prime n
  function automatic int blk_root(input int r, input int c, input int n);
    return ((3 * r + 5 * c) % (n - 1)) + 1;
  endfunction
endpackage

// File: rtl/eira_colmem.sv
module eira_colmem #(
  parameter int N  = 7,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eira_ptrgen.sv
module eira_ptrgen
  import eira_pkg::*;
#(
  parameter int N   = 7,
  parameter int AW  = 3,
  parameter int CW  = 3,
  parameter int COL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] ld_row,
  input  logic          step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] root_q;
  logic [AW:0]   nxt;

  assign nxt = {1'b0, addr} + {1'b0, root_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      root_q <= '0;
    end else if (load) begin
      root_q <= AW'(blk_root(int'(ld_row), COL, N));
      addr   <= AW'(blk_root(int'(ld_row), COL, N));
    end else if (step) begin
      if (nxt >= (AW+1)'(N)) addr <= AW'(nxt - (AW+1)'(N));
      else                   addr <= nxt[AW-1:0];
    end
  end

  // R4: pointer always addresses a valid local bit
  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, addr} < (AW+1)'(N));
  // R4: a step with a nonzero root always moves the pointer
  a_r4_move: assert property (@(posedge clk) disable iff (rst)
    (step && !load && N > 1) |=> addr != $past(addr));
endmodule

// File: rtl/eira_ldpc_enc.sv
module eira_ldpc_enc
  import eira_pkg::*;
#(
  parameter int N = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_last
);
  localparam int AW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(BLK);
  localparam logic [AW-1:0] LOC_MAX = AW'(N - 1);
  localparam logic [CW-1:0] BLK_MAX = CW'(BLK - 1);

  typedef enum logic [1:0] {S_LOAD, S_SYS, S_PAR} state_t;

  state_t        state;
  logic [CW-1:0] blk;
  logic [AW-1:0] loc;
  logic          acc;
  logic          fire, wr_en, last_pos, psum, pbit;
  logic [BLK-1:0] rd, act;
  logic [AW-1:0] gaddr [BLK];
  logic          gen_ld, gen_step;
  logic [CW-1:0] gen_row;

  assign in_ready = (state == S_LOAD);
  assign wr_en    = in_valid && in_ready;
  assign fire     = !out_valid || out_ready;
  assign last_pos = (blk == BLK_MAX) && (loc == LOC_MAX);

  assign gen_ld   = (state == S_SYS && fire && last_pos) ||
                    (state == S_PAR && fire && loc == LOC_MAX && blk != BLK_MAX);
  assign gen_step = (state == S_PAR) && fire && (loc != LOC_MAX);
  assign gen_row  = (state == S_PAR) ? blk + CW'(1) : '0;

  for (genvar c = 0; c < BLK; c++) begin : g_col
    logic [AW-1:0] raddr;
    assign raddr  = (state == S_PAR) ? gaddr[c] : loc;
    assign act[c] = blk_active(int'(blk), c);

    eira_colmem #(.N(N), .AW(AW)) u_mem (
      .clk(clk), .we(wr_en && blk == CW'(c)), .waddr(loc), .wdata(in_bit),
      .raddr(raddr), .rdata(rd[c]));

    eira_ptrgen #(.N(N), .AW(AW), .CW(CW), .COL(c)) u_gen (
      .clk(clk), .rst(rst), .load(gen_ld), .ld_row(gen_row),
      .step(gen_step), .addr(gaddr[c]));
  end

  assign psum = ^(rd & act);
  assign pbit = acc ^ psum;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_LOAD;
      blk       <= '0;
      loc       <= '0;
      acc       <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if ((state == S_LOAD && wr_en) || (state != S_LOAD && fire)) begin
        if (loc == LOC_MAX) begin
          loc <= '0;
          blk <= last_pos ? '0 : blk + CW'(1);
        end else begin
          loc <= loc + AW'(1);
        end
      end
      case (state)
        S_LOAD: if (wr_en && last_pos) state <= S_SYS;
        S_SYS: if (fire) begin
          out_valid <= 1'b1;
          out_bit   <= rd[blk];
          out_last  <= 1'b0;
          if (last_pos) begin
            state <= S_PAR;
            acc   <= 1'b0;
          end
        end
        S_PAR: if (fire) begin
          out_valid <= 1'b1;
          out_bit   <= pbit;
          out_last  <= last_pos;
          acc       <= pbit;
          if (last_pos) state <= S_LOAD;
        end
        default: state <= S_LOAD;
      endcase
    end
  end

  // R7: stalled output is frozen
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));
  // R8: once the final parity bit is held, loading is open again
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> in_ready);
  // R5: every block row has exactly three active block columns
  a_r5_three: assert property (@(posedge clk) disable iff (rst)
    (state == S_PAR) |-> ($countones(act) == 3));
  // R2: the cycle after the final bit of a load, input is closed
  a_r2_closed: assert property (@(posedge clk) disable iff (rst)
    (wr_en && last_pos) |=> !in_ready);
endmodule

// File: tb/eira_ldpc_enc_test.sv
module eira_ldpc_enc_test;
  localparam int N = 7;
  localparam int K = 7 * N;
  localparam int NV = 7;
  // mode: 0 all zero, 1 all one, 2 single bit at ARG, 3 LFSR seeded with ARG
  localparam int VMODE [NV] = '{0, 1, 2, 2, 3, 3, 3};
  localparam int VARG  [NV] = '{0, 0, 0, 48, 'h5A, 'h1D3, 'hBEEF};
  localparam int VSTALL[NV] = '{0, 1, 0, 1, 1, 0, 1};

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, out_last;
  int checks = 0, errors = 0;
  bit info [K];
  bit got [2*K];
  bit expp [K];

  eira_ldpc_enc #(.N(N)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last));

  always #5 clk = ~clk;

  function automatic bit act(int r, int c);
    int d = ((r - c) % 7 + 7) % 7;
    return (d == 0) || (d == 1) || (d == 3);
  endfunction

  function automatic int sel(int r, int c, int l);
    int g = ((3 * r + 5 * c) % (N - 1)) + 1;
    return c * N + (g * (l + 1)) % N;
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic fill(int mode, int arg);
    logic [15:0] lf = arg[15:0];
    for (int j = 0; j < K; j++) begin
      case (mode)
        0: info[j] = 1'b0;
        1: info[j] = 1'b1;
        2: info[j] = (j == arg);
        default: begin
          info[j] = lf[0];
          lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        end
      endcase
    end
  endtask

  task automatic load_bits(int count, int gap);
    int k = 0;
    for (int j = 0; j < count; j++) begin
      bit done = 0;
      while (!done) begin
        @(negedge clk);
        in_valid = !(gap != 0 && k % 4 == 3);
        in_bit = info[j];
        k++;
        #1;
        if (in_valid && in_ready) done = 1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_frame(int mode, int stall);
    int n = 0, k = 0, mism = 0, bad = 0, touched = 0, lastbad = 0;
    bit hold_pend = 0, hold_bit = 0, hold_last = 0, prev;
    load_bits(K, stall);
    #1;
    check(in_ready == 1'b0, "R2 in_ready after full load", in_ready, 0);
    while (n < 2 * K) begin
      @(negedge clk);
      if (hold_pend)
        check(out_valid && out_bit == hold_bit && out_last == hold_last,
              "R7 stalled output held", out_bit, hold_bit);
      out_ready = (stall != 0) ? (k % 3 != 0) : 1'b1;
      k++;
      #1;
      if (n < 2 * K - 1 && n > 0 && !in_ready && n < K) ; // R2 stays closed while emitting
      if (out_valid && out_ready) begin
        got[n] = out_bit;
        if (out_last != (n == 2 * K - 1)) lastbad++;
        if (n < 2 * K - 1 && in_ready) bad++;
        n++;
      end
      hold_pend = out_valid && !out_ready;
      hold_bit = out_bit;
      hold_last = out_last;
    end
    check(lastbad == 0, "R8 out_last only on final parity", lastbad, 0);
    check(bad == 0, "R2 in_ready low until frame done", bad, 0);
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    check(in_ready == 1'b1, "R8 in_ready after frame", in_ready, 1);
    // R3 systematic echo
    mism = 0;
    for (int j = 0; j < K; j++) if (got[j] != info[j]) mism++;
    check(mism == 0, "R3 systematic bits", mism, 0);
    // R4 expected parity from the generator rule
    prev = 0;
    for (int r = 0; r < 7; r++)
      for (int l = 0; l < N; l++) begin
        bit s = prev;
        for (int c = 0; c < 7; c++) if (act(r, c)) s ^= info[sel(r, c, l)];
        expp[r * N + l] = s;
        prev = s;
      end
    mism = 0;
    for (int t = 0; t < K; t++) if (got[K + t] != expp[t]) mism++;
    check(mism == 0, "R4 parity bits", mism, 0);
    // R6 syndrome of H over the received codeword
    mism = 0;
    for (int t = 0; t < K; t++) begin
      bit s = got[K + t] ^ ((t > 0) ? got[K + t - 1] : 1'b0);
      for (int c = 0; c < 7; c++) if (act(t / N, c)) s ^= got[sel(t / N, c, t % N)];
      if (s) mism++;
    end
    check(mism == 0, "R6 nonzero syndrome rows", mism, 0);
    if (mode == 2) begin
      for (int t = 0; t < K; t++)
        if (got[K + t] ^ ((t > 0) ? got[K + t - 1] : 1'b0)) touched++;
      check(touched == 3, "R5 check rows touched by one bit", touched, 3);
    end
    if (mode == 0) begin
      mism = 0;
      for (int t = 0; t < K; t++) if (got[K + t]) mism++;
      check(mism == 0, "R4 zero frame parity", mism, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      fill(VMODE[v], VARG[v]);
      run_frame(VMODE[v], VSTALL[v]);
    end
    // Directed: reset partway through a load (R1, R9)
    fill(1, 0);
    load_bits(K / 2 + 3, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset mid-load", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    fill(3, 'h0F1);
    run_frame(3, 1);
    check(errors == 0, "R9 frame after interrupted load", errors, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule